// File: doc/BRIEF.md
# Digital Keying Modulation Front End

This block sits in front of a numerically controlled oscillator and complex mixer. It turns data symbols into the four control values such a modulator needs: a frequency tuning word, a phase offset, and the real and imaginary amplitude inputs. A three-bit mode input selects the keying scheme. The supported schemes are amplitude keying, two-tone and eight-tone frequency keying, linear frequency modulation from a signed sample, and binary and quadrature phase keying.

A small write port loads the configuration registers. There are eight tone tuning words, a carrier tuning word and a deviation shift amount. A symbol-valid strobe captures the current mode, symbol bits and sample. The four outputs are registered. They change only on the clock edge that sees the strobe, and they hold their values at all other times.

Top module: `keying_front_end`

## Requirements
- R1: While reset (rst_n low) is asserted, and after its release until the first strobe, tune_word, phase_ofs, amp_a and amp_b are all zero.
- R2: The outputs take new values only on a rising edge where sym_valid is 1. At any other edge they keep their values, even when mode, sym_bits, fm_sample or the configuration registers change.
- R3: Mode 0 (amplitude keying): amp_a is sym_bits[0] in its MSB and zeros below, amp_b is 0, phase_ofs is 0, and tune_word is the carrier word.
- R4: Mode 1 (two-tone keying): tune_word is tone slot 0 when sym_bits[0] is 0 and tone slot 1 when it is 1. phase_ofs is 0, amp_a is the largest positive value (0x7F at 8 bits), and amp_b is 0.
- R5: Mode 2 (eight-tone keying): tune_word is tone slot k, where k is the unsigned value of sym_bits[2:0]. phase_ofs is 0, amp_a is the largest positive value, and amp_b is 0.
- R6: Mode 3 (linear FM): tune_word is the carrier word plus the signed fm_sample, sign-extended and shifted left by the stored shift amount (0 to 15), taken modulo 2^PHASE_W. phase_ofs is 0, amp_a is the largest positive value, and amp_b is 0.
- R7: Mode 4 (binary phase keying): phase_ofs is sym_bits[0] in its MSB and zeros below. tune_word is the carrier word, amp_a is the largest positive value, and amp_b is 0.
- R8: Mode 5 (quadrature phase keying): sym_bits[1:0] is Gray-mapped so that 00, 01, 11 and 10 give phase_ofs 0, 256, 512 and 768 (a quarter turn per step at 10 bits). tune_word is the carrier word, and amp_a and amp_b are both the largest positive value.
- R9: Modes 6 and 7 produce a plain carrier: tune_word is the carrier word, phase_ofs is 0, amp_a is the largest positive value, and amp_b is 0.
- R10: A write with cfg_we set stores cfg_data as follows: cfg_sel 0 to 7 loads tone slots 0 to 7, cfg_sel 8 loads the carrier word, and cfg_sel 9 loads the shift amount from cfg_data[3:0]. Writes to cfg_sel 10 to 15 change no register. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | PHASE_W (24) | Configuration write data |
| mode | input | 3 | Keying scheme select |
| sym_valid | input | 1 | Symbol strobe; outputs update on this edge |
| sym_bits | input | 3 | Symbol data bits |
| fm_sample | input | SAMP_W (8) | Signed sample for FM mode |
| tune_word | output | PHASE_W (24) | Tuning word to the oscillator |
| phase_ofs | output | OFS_W (10) | Phase offset to the oscillator |
| amp_a | output | AMP_W (8) | Real amplitude input to the mixer |
| amp_b | output | AMP_W (8) | Imaginary amplitude input to the mixer |

## Verification
Every output is due on the rising edge that samples sym_valid high, one register after the inputs. The bench therefore drives on a falling edge and reads the outputs at the next falling edge. A configuration write is registered on its own edge and only affects strobes in later cycles. The bench keeps writes and strobes in separate cycles, and it checks the hold behaviour across several idle edges after changing inputs and registers.

// File: rtl/keying_pkg.sv
package keying_pkg;

    typedef enum logic [2:0] {
        MODE_ASK  = 3'd0,
        MODE_BFSK = 3'd1,
        MODE_MFSK = 3'd2,
        MODE_FM   = 3'd3,
        MODE_BPSK = 3'd4,
        MODE_QPSK = 3'd5
    } key_mode_e;

    // Gray symbol to quadrant index: 00->0, 01->1, 11->2, 10->3
    function automatic logic [1:0] gray_to_quadrant(input logic [1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

endpackage

// File: rtl/keying_cfg_bank.sv
module keying_cfg_bank #(
    parameter int PHASE_W   = 24,
    parameter int NUM_TONES = 8,
    parameter int SHIFT_W   = 4,
    parameter int SEL_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [PHASE_W-1:0] cfg_data,
    output logic [PHASE_W-1:0] tone_q [NUM_TONES],
    output logic [PHASE_W-1:0] carrier_q,
    output logic [SHIFT_W-1:0] shift_q
);
    localparam logic [SEL_W-1:0] SEL_CARRIER = SEL_W'(NUM_TONES);
    localparam logic [SEL_W-1:0] SEL_SHIFT   = SEL_W'(NUM_TONES + 1);

    for (genvar i = 0; i < NUM_TONES; i++) begin : g_tone
        logic [PHASE_W-1:0] tone_d;
        always_comb begin
            tone_d = tone_q[i];
            if (cfg_we && cfg_sel == SEL_W'(i)) begin
                tone_d = cfg_data;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tone_q[i] <= '0;
            end else begin
                tone_q[i] <= tone_d;
            end
        end
    end

    logic [PHASE_W-1:0] carrier_d;
    logic [SHIFT_W-1:0] shift_d;

    always_comb begin
        carrier_d = carrier_q;
        shift_d   = shift_q;
        if (cfg_we && cfg_sel == SEL_CARRIER) begin
            carrier_d = cfg_data;
        end
        if (cfg_we && cfg_sel == SEL_SHIFT) begin
            shift_d = cfg_data[SHIFT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carrier_q <= '0;
            shift_q   <= '0;
        end else begin
            carrier_q <= carrier_d;
            shift_q   <= shift_d;
        end
    end
endmodule

// File: rtl/keying_freq_sel.sv
module keying_freq_sel
    import keying_pkg::*;
#(
    parameter int PHASE_W   = 24,
    parameter int NUM_TONES = 8,
    parameter int SHIFT_W   = 4,
    parameter int SAMP_W    = 8,
    parameter int SYM_W     = 3
) (
    input  logic [2:0]         mode,
    input  logic [SYM_W-1:0]   sym_bits,
    input  logic [SAMP_W-1:0]  fm_sample,
    input  logic [PHASE_W-1:0] tone_q [NUM_TONES],
    input  logic [PHASE_W-1:0] carrier_q,
    input  logic [SHIFT_W-1:0] shift_q,
    output logic [PHASE_W-1:0] tune_d
);
    localparam int IDX_W = $clog2(NUM_TONES);

    logic [IDX_W-1:0]   bin_idx;
    logic [IDX_W-1:0]   multi_idx;
    logic [PHASE_W-1:0] samp_ext;
    logic [PHASE_W-1:0] deviation;

    always_comb begin
        bin_idx   = IDX_W'(sym_bits[0]);
        multi_idx = IDX_W'(sym_bits);
        samp_ext  = {{(PHASE_W-SAMP_W){fm_sample[SAMP_W-1]}}, fm_sample};
        deviation = samp_ext << shift_q;
        case (key_mode_e'(mode))
            MODE_BFSK: tune_d = tone_q[bin_idx];
            MODE_MFSK: tune_d = tone_q[multi_idx];
            MODE_FM:   tune_d = carrier_q + deviation;
            default:   tune_d = carrier_q;
        endcase
    end
endmodule

// File: rtl/keying_shape.sv
module keying_shape
    import keying_pkg::*;
#(
    parameter int OFS_W = 10,
    parameter int AMP_W = 8,
    parameter int SYM_W = 3
) (
    input  logic [2:0]       mode,
    input  logic [SYM_W-1:0] sym_bits,
    output logic [OFS_W-1:0] ofs_d,
    output logic [AMP_W-1:0] a_d,
    output logic [AMP_W-1:0] b_d
);
    localparam logic [AMP_W-1:0] AMP_MAX = {1'b0, {(AMP_W-1){1'b1}}};

    always_comb begin
        ofs_d = '0;
        a_d   = AMP_MAX;
        b_d   = '0;
        case (key_mode_e'(mode))
            MODE_ASK: begin
                a_d = {sym_bits[0], {(AMP_W-1){1'b0}}};
            end
            MODE_BPSK: begin
                ofs_d = {sym_bits[0], {(OFS_W-1){1'b0}}};
            end
            MODE_QPSK: begin
                ofs_d = {gray_to_quadrant(sym_bits[1:0]), {(OFS_W-2){1'b0}}};
                b_d   = AMP_MAX;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/keying_front_end.sv
module keying_front_end #(
    parameter int PHASE_W   = 24,
    parameter int OFS_W     = 10,
    parameter int AMP_W     = 8,
    parameter int SAMP_W    = 8,
    parameter int NUM_TONES = 8,
    parameter int SHIFT_W   = 4,
    parameter int SEL_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [PHASE_W-1:0] cfg_data,
    input  logic [2:0]         mode,
    input  logic               sym_valid,
    input  logic [2:0]         sym_bits,
    input  logic [SAMP_W-1:0]  fm_sample,
    output logic [PHASE_W-1:0] tune_word,
    output logic [OFS_W-1:0]   phase_ofs,
    output logic [AMP_W-1:0]   amp_a,
    output logic [AMP_W-1:0]   amp_b
);
    localparam int SYM_W = 3;

    typedef struct packed {
        logic [PHASE_W-1:0] tune;
        logic [OFS_W-1:0]   ofs;
        logic [AMP_W-1:0]   a;
        logic [AMP_W-1:0]   b;
    } ctl_t;

    logic [PHASE_W-1:0] tone_q [NUM_TONES];
    logic [PHASE_W-1:0] carrier_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [PHASE_W-1:0] tune_sel;
    logic [OFS_W-1:0]   ofs_sel;
    logic [AMP_W-1:0]   a_sel;
    logic [AMP_W-1:0]   b_sel;
    ctl_t               ctl_d;
    ctl_t               ctl_q;

    keying_cfg_bank #(
        .PHASE_W(PHASE_W), .NUM_TONES(NUM_TONES), .SHIFT_W(SHIFT_W), .SEL_W(SEL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .tone_q(tone_q), .carrier_q(carrier_q), .shift_q(shift_q)
    );

    keying_freq_sel #(
        .PHASE_W(PHASE_W), .NUM_TONES(NUM_TONES), .SHIFT_W(SHIFT_W),
        .SAMP_W(SAMP_W), .SYM_W(SYM_W)
    ) u_freq (
        .mode(mode), .sym_bits(sym_bits), .fm_sample(fm_sample), .tone_q(tone_q),
        .carrier_q(carrier_q), .shift_q(shift_q), .tune_d(tune_sel)
    );

    keying_shape #(
        .OFS_W(OFS_W), .AMP_W(AMP_W), .SYM_W(SYM_W)
    ) u_shape (
        .mode(mode), .sym_bits(sym_bits), .ofs_d(ofs_sel), .a_d(a_sel), .b_d(b_sel)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (sym_valid) begin
            ctl_d.tune = tune_sel;
            ctl_d.ofs  = ofs_sel;
            ctl_d.a    = a_sel;
            ctl_d.b    = b_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tune_word = ctl_q.tune;
    assign phase_ofs = ctl_q.ofs;
    assign amp_a     = ctl_q.a;
    assign amp_b     = ctl_q.b;
endmodule

// File: rtl/keying_front_end_chk.sv
module keying_front_end_chk #(
    parameter int PHASE_W = 24,
    parameter int OFS_W   = 10,
    parameter int AMP_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         mode,
    input logic               sym_valid,
    input logic [2:0]         sym_bits,
    input logic [PHASE_W-1:0] tune_word,
    input logic [OFS_W-1:0]   phase_ofs,
    input logic [AMP_W-1:0]   amp_a,
    input logic [AMP_W-1:0]   amp_b
);
    localparam logic [AMP_W-1:0] AMAX = {1'b0, {(AMP_W-1){1'b1}}};

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> ($stable(tune_word) && $stable(phase_ofs) && $stable(amp_a) && $stable(amp_b)));

    p_ask_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && mode == 3'd0) |=>
        (amp_b == '0 && phase_ofs == '0 && amp_a[AMP_W-2:0] == '0
         && amp_a[AMP_W-1] == $past(sym_bits[0])));

    p_fsk_zero_ofs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && (mode == 3'd1 || mode == 3'd2 || mode == 3'd3)) |=>
        (phase_ofs == '0 && amp_a == AMAX && amp_b == '0));

    p_bpsk_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && mode == 3'd4) |=>
        (amp_a == AMAX && amp_b == '0 && phase_ofs[OFS_W-2:0] == '0
         && phase_ofs[OFS_W-1] == $past(sym_bits[0])));

    p_qpsk_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && mode == 3'd5) |=>
        (amp_a == AMAX && amp_b == AMAX && phase_ofs[OFS_W-3:0] == '0));

    p_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && mode[2:1] == 2'b11) |=>
        (amp_a == AMAX && amp_b == '0 && phase_ofs == '0));
endmodule

bind keying_front_end keying_front_end_chk #(
    .PHASE_W(PHASE_W), .OFS_W(OFS_W), .AMP_W(AMP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sym_valid(sym_valid), .sym_bits(sym_bits),
    .tune_word(tune_word), .phase_ofs(phase_ofs), .amp_a(amp_a), .amp_b(amp_b)
);

// File: tb/sim_keying_front_end.sv
`timescale 1ns/1ps
module sim_keying_front_end;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [23:0] cfg_data = '0;
    logic [2:0]  mode = '0;
    logic        sym_valid = 1'b0;
    logic [2:0]  sym_bits = '0;
    logic [7:0]  fm_sample = '0;
    logic [23:0] tune_word;
    logic [9:0]  phase_ofs;
    logic [7:0]  amp_a;
    logic [7:0]  amp_b;

    int n_checks = 0;
    int n_errors = 0;
    logic [23:0] tones [8];
    logic [23:0] carrier;

    always #2.5 clk = ~clk;

    keying_front_end u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .mode(mode), .sym_valid(sym_valid), .sym_bits(sym_bits), .fm_sample(fm_sample),
        .tune_word(tune_word), .phase_ofs(phase_ofs), .amp_a(amp_a), .amp_b(amp_b)
    );

    task automatic check(input string req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic expect_all(input string req, input logic [23:0] t, input logic [9:0] o,
                              input logic [7:0] a, input logic [7:0] b);
        check(req, "tune_word", 32'(tune_word), 32'(t));
        check(req, "phase_ofs", 32'(phase_ofs), 32'(o));
        check(req, "amp_a", 32'(amp_a), 32'(a));
        check(req, "amp_b", 32'(amp_b), 32'(b));
    endtask

    task automatic cfg_write(input logic [3:0] sel, input logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Strobe one symbol; outputs are read at the falling edge after the capture edge
    task automatic send(input logic [2:0] m, input logic [2:0] bits, input logic [7:0] samp);
        @(negedge clk);
        mode = m; sym_bits = bits; fm_sample = samp; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic test_reset();
        expect_all("R1", 24'h0, 10'h0, 8'h0, 8'h0);
    endtask

    task automatic test_config();
        for (int i = 0; i < 8; i++) begin
            tones[i] = 24'h100000 + 24'(i * 24'h01_1111);
            cfg_write(4'(i), tones[i]);
        end
        carrier = 24'h400000;
        cfg_write(4'd8, carrier);
        cfg_write(4'd9, 24'h0);
        cfg_write(4'd12, 24'hABCDEF);
        cfg_write(4'd15, 24'h123456);
        send(3'd7, 3'd0, 8'h00);
        check("R10", "carrier untouched by unused selects", 32'(tune_word), 32'(carrier));
    endtask

    task automatic test_ask();
        send(3'd0, 3'd1, 8'h00);
        expect_all("R3", carrier, 10'h0, 8'h80, 8'h00);
        send(3'd0, 3'd0, 8'h00);
        expect_all("R3", carrier, 10'h0, 8'h00, 8'h00);
    endtask

    task automatic test_bfsk();
        send(3'd1, 3'd0, 8'h00);
        expect_all("R4", tones[0], 10'h0, 8'h7F, 8'h00);
        send(3'd1, 3'd1, 8'h00);
        expect_all("R4", tones[1], 10'h0, 8'h7F, 8'h00);
        send(3'd1, 3'd6, 8'h00);
        expect_all("R4", tones[0], 10'h0, 8'h7F, 8'h00);
    endtask

    task automatic test_mfsk();
        for (int k = 7; k >= 0; k--) begin
            send(3'd2, 3'(k), 8'h00);
            expect_all("R5", tones[k], 10'h0, 8'h7F, 8'h00);
        end
    endtask

    task automatic fm_case(input int shift, input logic [7:0] samp);
        int sv;
        logic [23:0] exp_t;
        cfg_write(4'd9, 24'(shift));
        sv = int'($signed(samp));
        exp_t = carrier + 24'(sv * (1 << shift));
        send(3'd3, 3'd0, samp);
        expect_all("R6", exp_t, 10'h0, 8'h7F, 8'h00);
    endtask

    task automatic test_fm();
        fm_case(0, 8'd5);
        fm_case(4, 8'h80);
        fm_case(15, 8'h7F);
        fm_case(15, 8'h80);
        fm_case(3, 8'hFF);
    endtask

    task automatic test_bpsk();
        send(3'd4, 3'd1, 8'h00);
        expect_all("R7", carrier, 10'h200, 8'h7F, 8'h00);
        send(3'd4, 3'd0, 8'h00);
        expect_all("R7", carrier, 10'h000, 8'h7F, 8'h00);
    endtask

    task automatic test_qpsk();
        logic [9:0] exp_o [4];
        exp_o[0] = 10'd0;   // 00
        exp_o[1] = 10'd256; // 01
        exp_o[3] = 10'd512; // 11
        exp_o[2] = 10'd768; // 10
        for (int s = 0; s < 4; s++) begin
            send(3'd5, 3'(s), 8'h00);
            expect_all("R8", carrier, exp_o[s], 8'h7F, 8'h7F);
        end
    endtask

    task automatic test_plain();
        send(3'd6, 3'd7, 8'h55);
        expect_all("R9", carrier, 10'h0, 8'h7F, 8'h00);
        send(3'd7, 3'd5, 8'hAA);
        expect_all("R9", carrier, 10'h0, 8'h7F, 8'h00);
    endtask

    task automatic test_hold();
        send(3'd5, 3'd3, 8'h00);
        @(negedge clk);
        mode = 3'd2; sym_bits = 3'd6; fm_sample = 8'h33;
        cfg_write(4'd8, 24'h0ABCDE);
        cfg_write(4'd2, 24'h777777);
        repeat (3) @(negedge clk);
        expect_all("R2", carrier, 10'd512, 8'h7F, 8'h7F);
        carrier = 24'h0ABCDE;
        send(3'd6, 3'd0, 8'h00);
        check("R2", "new carrier after strobe", 32'(tune_word), 32'(carrier));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_config();
        test_ask();
        test_bfsk();
        test_mfsk();
        test_fm();
        test_bpsk();
        test_qpsk();
        test_plain();
        test_hold();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule